// File: doc/BRIEF.md
# Frame address sequencer for a memory-streamed video waveform

This block produces the read address for a frame memory that stores one byte for every pixel-clock period of the whole video waveform. For a 640x480 frame that is 800 clocks per line and 525 lines, porches and sync periods included. The sync levels live inside the stored bytes, so the display side does no timing decode of its own. It steps an address counter once per pixel clock, and the byte read back is latched into an output register that feeds the video pins.

The counter is not cleared by comparing it against a frame length. Instead the vertical sync bit of the byte read from memory is watched. A low-to-high change on that bit raises a clear request that lasts exactly one clock, and the counter goes to zero on the following edge. An arming flag drops as the request fires and keeps further requests out while the bit stays high, so there is one clear per frame. The frame therefore starts at the sync edge, and the host must store its image rotated in address space to match. If no edge comes, the counter wraps at its top value.

In host mode an external controller takes over the counter's step and clear controls and writes the memory through a write strobe. It has no address input: it clears the counter and then steps it to reach a location. The clear line keeps its last driven level whenever the controller stops driving it, so a clear held across the handover keeps the counter at zero until the controller releases it in display mode. The output register has a load enable of its own, so the sync levels on the pins can be frozen at any value.

Top module: `frame_addr_seq`

## Requirements
- R1: While `rst` is high, at each clock edge, `mem_addr` and `pix` go to 0, the clear request drops, the arming flag drops and the held clear level goes to 0.
- R2: In display mode (`host_mode`=0), with no clear active and no request pending, `mem_addr` increases by one on every clock.
- R3: When bit VS_BIT of `mem_rdata` (default bit 7) is 1 at a clock edge, and it was 0 at the edge before, a one-clock request is raised. The edge after that sets `mem_addr` to 0. If the high bit is first seen at address A, the sequence is A, A+1, 0.
- R4: While the sync bit stays high, no further request is raised. A new clear needs the bit to go low and then high again.
- R5: In host mode `mem_addr` steps by one only on clocks where `host_inc` is 1. A driven clear (`host_clr_drv`=1, `host_clr`=1) sets it to 0, and the clear wins over `host_inc`.
- R6: When `host_clr_drv` is 0, the clear level is the last value driven while `host_clr_drv` was 1, in either mode. A held clear keeps `mem_addr` at 0 in display mode.
- R7: On each clock edge where `out_en` is 1, `pix` loads `mem_rdata`; on edges where `out_en` is 0, `pix` keeps its value.
- R8: `mem_we` is 1 only when `host_mode` and `host_we` are both 1. `mem_oe` is the inverse of `mem_we`, so it stays 1 throughout display mode. `mem_wdata` carries `host_wdata`.
- R9: From the top address 2^ADDR_W-1 the counter steps to 0.
- R10: A rising sync bit seen in host mode raises no request and causes no clear.
- R11: A sync bit that is already high when `rst` is released raises no request until it has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| host_mode | input | 1 | 1: host controls step and clear; 0: display streaming |
| host_inc | input | 1 | Host step request (host mode) |
| host_clr_drv | input | 1 | Host is driving the clear line |
| host_clr | input | 1 | Clear level driven by the host |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write byte |
| out_en | input | 1 | Output register load enable |
| mem_rdata | input | DATA_W | Byte read from frame memory |
| mem_addr | output | ADDR_W | Frame memory address |
| mem_wdata | output | DATA_W | Byte written to frame memory |
| mem_we | output | 1 | Frame memory write enable |
| mem_oe | output | 1 | Frame memory output enable |
| pix | output | DATA_W | Latched output byte (video and sync bits) |

## Verification
A 64-location configuration is filled by the host through the clear-and-step path. The fill covers every address, including the wrap from the top address. The stored image has its sync bit high over a band that runs from address 40 through the top and on to address 4. As a result the streaming run meets a real rising edge, a sync bit that stays high after the clear, and a low stretch. These tell apart a correct one-shot clear, a clear that repeats while the bit is high, and a clear that comes a cycle early or late. Host-mode walks across the same edge check that no clear happens there, and a clear held across the mode change checks the held line level. A reset taken while the sync bit is high checks that the arming flag starts cleared. A stretch with the output enable low checks that the latched byte is frozen.

// File: rtl/fas_pkg.sv
package fas_pkg;
    typedef enum logic {
        MODE_DISPLAY = 1'b0,
        MODE_HOST    = 1'b1
    } mode_e;

    typedef struct packed {
        logic armed;
        logic req;
    } edge_st_t;
endpackage

// File: rtl/fas_addr_ctr.sv
module fas_addr_ctr #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  fas_pkg::mode_e    mode,
    input  logic              host_inc,
    input  logic              host_clr_drv,
    input  logic              host_clr,
    input  logic              vs_req,
    output logic [ADDR_W-1:0] addr,
    output logic              clr_hold
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              hold;
    } ctr_st_t;

    ctr_st_t st_q, st_d;
    logic    clr_line;
    logic    step;

    always_comb begin
        clr_line = host_clr_drv ? host_clr : st_q.hold;
        step     = (mode == fas_pkg::MODE_DISPLAY) || host_inc;
        st_d      = st_q;
        st_d.hold = clr_line;
        if (clr_line || vs_req)
            st_d.addr = '0;
        else if (step)
            st_d.addr = st_q.addr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign addr     = st_q.addr;
    assign clr_hold = st_q.hold;
endmodule

// File: rtl/fas_vs_edge.sv
module fas_vs_edge (
    input  logic           clk,
    input  logic           rst,
    input  fas_pkg::mode_e mode,
    input  logic           vs_bit,
    output logic           req
);
    fas_pkg::edge_st_t st_q, st_d;

    always_comb begin
        st_d.req   = vs_bit && st_q.armed && (mode == fas_pkg::MODE_DISPLAY);
        st_d.armed = !vs_bit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign req = st_q.req;
endmodule

// File: rtl/fas_out_reg.sv
module fas_out_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] pix_q, pix_d;

    always_comb begin
        pix_d = load ? din : pix_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pix_q <= '0;
        else
            pix_q <= pix_d;
    end

    assign dout = pix_q;
endmodule

// File: rtl/frame_addr_seq.sv
module frame_addr_seq #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int VS_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic              host_inc,
    input  logic              host_clr_drv,
    input  logic              host_clr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              out_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_oe,
    output logic [DATA_W-1:0] pix
);
    fas_pkg::mode_e mode;
    logic           vs_req;
    logic           clr_hold;

    assign mode      = host_mode ? fas_pkg::MODE_HOST : fas_pkg::MODE_DISPLAY;
    assign mem_we    = (mode == fas_pkg::MODE_HOST) && host_we;
    assign mem_oe    = !mem_we;
    assign mem_wdata = host_wdata;

    fas_addr_ctr #(.ADDR_W(ADDR_W)) i_ctr (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .host_inc     (host_inc),
        .host_clr_drv (host_clr_drv),
        .host_clr     (host_clr),
        .vs_req       (vs_req),
        .addr         (mem_addr),
        .clr_hold     (clr_hold)
    );

    fas_vs_edge i_edge (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .vs_bit (mem_rdata[VS_BIT]),
        .req    (vs_req)
    );

    fas_out_reg #(.DATA_W(DATA_W)) i_out (
        .clk  (clk),
        .rst  (rst),
        .load (out_en),
        .din  (mem_rdata),
        .dout (pix)
    );
endmodule

// File: rtl/fas_chk.sv
module fas_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_mode,
    input logic              host_inc,
    input logic              host_clr_drv,
    input logic              host_clr,
    input logic              host_we,
    input logic              out_en,
    input logic              mem_we,
    input logic              mem_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] pix,
    input logic              vs_req,
    input logic              clr_hold
);
    logic clr_now;
    assign clr_now = host_clr_drv ? host_clr : clr_hold;

    // R8
    always_comb begin
        oe_we_excl_chk: assert (mem_oe == !mem_we);
    end

    // R1
    reset_addr_chk: assert property (@(posedge clk) rst |=> (mem_addr == '0) && !vs_req);

    // R2
    disp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_mode && !vs_req && !clr_now) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R3
    req_clear_chk: assert property (@(posedge clk) disable iff (rst)
        vs_req |=> mem_addr == '0);

    // R4
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        vs_req |=> !vs_req);

    // R5
    host_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_mode && host_clr_drv && !host_clr && !host_inc && !vs_req) |=> $stable(mem_addr));

    // R5
    host_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (host_clr_drv && host_clr) |=> mem_addr == '0);

    // R7
    pix_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> $stable(pix));

    // R8
    we_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (host_mode && host_we));
endmodule

bind frame_addr_seq fas_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .host_mode    (host_mode),
    .host_inc     (host_inc),
    .host_clr_drv (host_clr_drv),
    .host_clr     (host_clr),
    .host_we      (host_we),
    .out_en       (out_en),
    .mem_we       (mem_we),
    .mem_oe       (mem_oe),
    .mem_addr     (mem_addr),
    .pix          (pix),
    .vs_req       (vs_req),
    .clr_hold     (clr_hold)
);

// File: tb/test_frame_addr_seq.sv
module test_frame_addr_seq;
    localparam int PERIOD = 10;
    localparam int AW     = 6;
    localparam int DW     = 8;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_mode = 1'b0, host_inc = 1'b0, host_clr_drv = 1'b0, host_clr = 1'b0;
    logic          host_we = 1'b0, out_en = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] mem_rdata, mem_wdata, pix;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_oe;
    logic [DW-1:0] mem [DEPTH];

    int n_chk  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    frame_addr_seq #(.ADDR_W(AW), .DATA_W(DW), .VS_BIT(7)) i_frame_addr_seq (
        .clk(clk), .rst(rst), .host_mode(host_mode), .host_inc(host_inc),
        .host_clr_drv(host_clr_drv), .host_clr(host_clr), .host_we(host_we),
        .host_wdata(host_wdata), .out_en(out_en), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_oe(mem_oe), .pix(pix)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem_oe ? mem[mem_addr] : '0;

    function automatic logic [DW-1:0] pat(int a);
        logic vs;
        vs = (a >= 40) || (a <= 4);
        return {vs, 7'(a * 3 + 1)};
    endfunction

    function automatic logic vsb(int a);
        return pat(a)[7];
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Streams for a number of clocks, modelling the expected address arithmetically.
    task automatic stream(int cycles, int e0, logic prev0, string first_tag, int first_n);
        int   e    = e0;
        logic prev = prev0;
        logic pend = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            int    ne;
            logic  npend;
            string tag;
            ne    = pend ? 0 : (e + 1) % DEPTH;
            npend = vsb(e) && !prev;
            tag   = pend ? "R3" : ((vsb(e) && prev) ? "R4" : "R2");
            if (k < first_n) tag = first_tag;
            tick();
            chk(tag, int'(mem_addr), ne);
            chk("R7", int'(pix), int'(pat(e)));
            prev = vsb(e);
            pend = npend;
            e    = ne;
        end
    endtask

    initial begin
        #(PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [DW-1:0] frozen;
        tick(); tick(); tick();
        chk("R1", int'(mem_addr), 0);
        chk("R1", int'(pix), 0);
        rst = 1'b0;

        // host fill by clear and step
        host_mode = 1'b1; host_clr_drv = 1'b1; host_clr = 1'b1;
        tick();
        chk("R5", int'(mem_addr), 0);
        host_clr = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            host_we = 1'b1; host_inc = 1'b1; host_wdata = pat(i);
            #1;
            chk("R8", int'(mem_we), 1);
            chk("R8", int'(mem_oe), 0);
            chk("R8", int'(mem_wdata), int'(pat(i)));
            tick();
            chk(i == DEPTH - 1 ? "R9" : "R5", int'(mem_addr), (i + 1) % DEPTH);
        end
        host_we = 1'b0; host_inc = 1'b0;
        #1;
        chk("R8", int'(mem_oe), 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5", int'(mem_addr), 0);
        end

        // host walk across the sync edge: no clear
        host_inc = 1'b1;
        for (int k = 0; k < 45; k++) begin
            tick();
            chk("R10", int'(mem_addr), k + 1);
        end
        host_clr = 1'b1;
        tick();
        chk("R5", int'(mem_addr), 0);

        // handover with clear held
        host_inc = 1'b0;
        tick();
        host_clr_drv = 1'b0;
        host_mode = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6", int'(mem_addr), 0);
        end
        host_we = 1'b1;
        #1;
        chk("R8", int'(mem_oe), 1);
        chk("R8", int'(mem_we), 0);
        host_we = 1'b0;
        host_clr_drv = 1'b1; host_clr = 1'b0; out_en = 1'b1;
        tick();
        chk("R6", int'(mem_addr), 1);
        host_clr_drv = 1'b0;
        stream(150, 1, 1'b1, "R6", 2);

        // frozen output register
        out_en = 1'b0;
        frozen = pix;
        for (int k = 0; k < 10; k++) begin
            tick();
            chk("R7", int'(pix), int'(frozen));
        end
        out_en = 1'b1;

        // reset while sync bit is high
        rst = 1'b1;
        tick(); tick();
        chk("R1", int'(mem_addr), 0);
        rst = 1'b0;
        stream(100, 0, 1'b1, "R11", 6);

        summary();
    end
endmodule